// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one burst request into the series of column addresses that a synchronous DRAM controller drives during a read or write burst. The caller supplies a starting column within a 256-column row, a burst length code, an ordering choice (linear or XOR-interleaved), whether the access is a write, and the single-write mode bit. For each enabled clock after the request, the block puts out one column address. It marks the final beat and ends the burst by itself.

A full-row burst does not end by itself. It walks the whole row, wrapping past the top column, until the caller stops it. A stop request ends any burst early, and a new request replaces the one in progress. When the clock enable input is low, the sequencer holds its state completely, as the memory's internal clock does during clock suspend. Issuing commands, moving data and DRAM timing are handled outside this block.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, and whenever no burst is running, `valid_o` and `last_o` are 0 and `col_o` is 0 after reset.
- R2: A request (`start_i`=1 with `cke_i`=1) sampled at a rising edge makes `valid_o`=1 and `col_o` equal to the requested start column from the next cycle, and beat k appears k cycles later.
- R3: In linear order with burst length L, the low log2(L) bits of beat k equal (start + k) mod L, and the upper column bits stay equal to those of the start column.
- R4: In interleaved order (`order_il_i`=1) with burst length L, the low log2(L) bits of beat k equal start XOR k, and the upper bits stay fixed.
- R5: For a finite burst of length L, `last_o` is 1 on beat L-1 only, and `valid_o` falls in the following cycle unless a new request arrives.
- R6: Length codes on `bl_code_i`: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a full row. Codes 100, 101 and 110 give length 1.
- R7: A full-row burst counts the column upward by one per beat from the start column, wraps from 255 to 0, never raises `last_o`, runs until stopped, and uses linear order even when interleave is requested.
- R8: With `single_wr_i`=1, a write (`is_write_i`=1) is a one-beat burst for any length code. A read still uses the programmed length.
- R9: `stop_i`=1 sampled with `cke_i`=1 and no request ends the burst, so `valid_o` is 0 from the next cycle. A request sampled at the same edge takes priority over the stop.
- R10: A request that arrives during a burst aborts that burst, and the new sequence starts from beat 0 in the next cycle.
- R11: While `cke_i` is low at a rising edge, `col_o`, `valid_o` and `last_o` keep their values, and `start_i` and `stop_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke_i | input | 1 | Clock enable; low freezes the sequencer |
| start_i | input | 1 | Begin a new burst |
| start_col_i | input | 8 | Starting column |
| bl_code_i | input | 3 | Burst length code |
| order_il_i | input | 1 | 1 selects interleaved order, 0 selects linear |
| is_write_i | input | 1 | Request is a write |
| single_wr_i | input | 1 | Single-write mode bit |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | 8 | Current column address |
| valid_o | output | 1 | A burst beat is present on `col_o` |
| last_o | output | 1 | Current beat is the final one |

## Verification
Bursts of lengths 2, 4 and 8 start from unaligned columns in both orders. Linear and XOR ordering give different sequences from the same start, and the mod-L wrap stays inside its block, so the tests tell apart which order was used and whether a carry leaked into the upper bits. A full-row burst starting near column 255 shows the row wrap and the missing end marker. It is run with interleave requested, to confirm that the request is ignored. Reserved codes, and writes with the single-write bit both set and clear, separate the length decode from the write override. Stop, restart and clock-suspend cases in the middle of a burst show where each one takes effect, and show that requests made during a suspend are dropped.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [2:0] {
    BLC_1    = 3'b000,
    BLC_2    = 3'b001,
    BLC_4    = 3'b010,
    BLC_8    = 3'b011,
    BLC_PAGE = 3'b111
  } blc_e;
endpackage

// File: rtl/sdc_rst_sync.sv
module sdc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/sdc_len_decode.sv
module sdc_len_decode #(
  parameter int COL_W = 8
) (
  input  logic [2:0]       code_i,
  input  logic             is_write_i,
  input  logic             single_wr_i,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o
);
  import sdc_pkg::*;

  localparam logic [COL_W-1:0] MSK_1 = '0;
  localparam logic [COL_W-1:0] MSK_2 = COL_W'(1);
  localparam logic [COL_W-1:0] MSK_4 = COL_W'(3);
  localparam logic [COL_W-1:0] MSK_8 = COL_W'(7);
  localparam logic [COL_W-1:0] MSK_P = '1;

  always_comb begin
    mask_o = MSK_1;
    page_o = 1'b0;
    if (!(is_write_i && single_wr_i)) begin
      case (blc_e'(code_i))
        BLC_2:    mask_o = MSK_2;
        BLC_4:    mask_o = MSK_4;
        BLC_8:    mask_o = MSK_8;
        BLC_PAGE: begin
          mask_o = MSK_P;
          page_o = 1'b1;
        end
        default:  mask_o = MSK_1;
      endcase
    end
  end
endmodule

// File: rtl/sdc_beat_ctr.sv
module sdc_beat_ctr #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             page_i,
  input  logic             il_i,
  output logic             active_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o,
  output logic             il_o,
  output logic             last_o
);
  logic             act_q,  act_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic             page_q, page_d;
  logic             il_q,   il_d;
  logic             last_w;

  assign last_w = act_q && !page_q && (beat_q == mask_q);

  always_comb begin
    act_d  = act_q;
    base_d = base_q;
    beat_d = beat_q;
    mask_d = mask_q;
    page_d = page_q;
    il_d   = il_q;
    if (cke_i) begin
      if (start_i) begin
        act_d  = 1'b1;
        base_d = base_i;
        beat_d = '0;
        mask_d = mask_i;
        page_d = page_i;
        il_d   = il_i && !page_i;
      end else if (stop_i) begin
        act_d = 1'b0;
      end else if (act_q) begin
        if (last_w) act_d = 1'b0;
        else        beat_d = beat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
      page_q <= 1'b0;
      il_q   <= 1'b0;
    end else begin
      act_q  <= act_d;
      base_q <= base_d;
      beat_q <= beat_d;
      mask_q <= mask_d;
      page_q <= page_d;
      il_q   <= il_d;
    end
  end

  assign active_o = act_q;
  assign base_o   = base_q;
  assign beat_o   = beat_q;
  assign mask_o   = mask_q;
  assign il_o     = il_q;
  assign last_o   = last_w;
endmodule

// File: rtl/sdc_addr_map.sv
module sdc_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             il_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] lin_w;
  logic [COL_W-1:0] xor_w;

  assign lin_w = base_i + beat_i;
  assign xor_w = base_i ^ beat_i;

  for (genvar gi = 0; gi < COL_W; gi++) begin : g_bit
    assign col_o[gi] = mask_i[gi] ? (il_i ? xor_w[gi] : lin_w[gi]) : base_i[gi];
  end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_i,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             order_il_i,
  input  logic             is_write_i,
  input  logic             single_wr_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic             rst_sync_n;
  logic [COL_W-1:0] req_mask;
  logic             req_page;
  logic [COL_W-1:0] cur_base;
  logic [COL_W-1:0] cur_beat;
  logic [COL_W-1:0] cur_mask;
  logic             cur_il;

  sdc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sdc_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i      (bl_code_i),
    .is_write_i  (is_write_i),
    .single_wr_i (single_wr_i),
    .mask_o      (req_mask),
    .page_o      (req_page)
  );

  sdc_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cke_i    (cke_i),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .base_i   (start_col_i),
    .mask_i   (req_mask),
    .page_i   (req_page),
    .il_i     (order_il_i),
    .active_o (valid_o),
    .base_o   (cur_base),
    .beat_o   (cur_beat),
    .mask_o   (cur_mask),
    .il_o     (cur_il),
    .last_o   (last_o)
  );

  sdc_addr_map #(.COL_W(COL_W)) u_map (
    .base_i (cur_base),
    .beat_i (cur_beat),
    .mask_i (cur_mask),
    .il_i   (cur_il),
    .col_o  (col_o)
  );
endmodule

// File: rtl/sdc_chk.sv
module sdc_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke_i,
  input logic             start_i,
  input logic             stop_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             is_write_i,
  input logic             single_wr_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    cke_i && start_i |=> valid_o && (col_o == $past(start_col_i))); // R2

  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o); // R5

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    cke_i && last_o && !start_i |=> !valid_o); // R5

  AST_RUN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    cke_i && valid_o && !last_o && !start_i && !stop_i |=> valid_o); // R7

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cke_i && start_i && is_write_i && single_wr_i |=> last_o); // R8

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    cke_i && stop_i && !start_i |=> !valid_o); // R9

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_i |=> $stable(col_o) && $stable(valid_o) && $stable(last_o)); // R11
endmodule

bind sdram_col_seq sdc_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cke_i       (cke_i),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .start_col_i (start_col_i),
  .is_write_i  (is_write_i),
  .single_wr_i (single_wr_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o)
);

// File: tb/sim_sdram_col_seq.sv
module sim_sdram_col_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1;
  logic       start = 1'b0;
  logic [7:0] scol = '0;
  logic [2:0] code = '0;
  logic       il = 1'b0;
  logic       wr = 1'b0;
  logic       sw = 1'b0;
  logic       stop = 1'b0;
  logic [7:0] col;
  logic       valid;
  logic       last;

  typedef struct {
    logic [7:0] c;
    logic       l;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   nchk = 0;
  int   nfail = 0;
  bit   mon_on = 1'b0;
  logic cke_q = 1'b1;
  logic [7:0] prev_col = '0;

  always #4 clk = ~clk;

  sdram_col_seq u0 (
    .clk(clk), .rst_n(rst_n), .cke_i(cke), .start_i(start), .start_col_i(scol),
    .bl_code_i(code), .order_il_i(il), .is_write_i(wr), .single_wr_i(sw),
    .stop_i(stop), .col_o(col), .valid_o(valid), .last_o(last)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  function automatic logic [7:0] model(input logic [7:0] s, input logic [7:0] m,
                                       input bit xo, input int k);
    logic [7:0] kk;
    logic [7:0] ofs;
    kk  = 8'(k);
    ofs = xo ? (s ^ kk) : (s + kk);
    return (s & ~m) | (ofs & m);
  endfunction

  // Driver: pushes expected beats, then drives the request (entered just after a rising edge)
  task automatic burst(input logic [7:0] c, input logic [2:0] bc, input bit xo,
                       input bit w, input bit s1, input int run,
                       input bit do_stop, input bit chain, input string tag);
    int len;
    bit page;
    int n;
    logic [7:0] m;
    page = (bc == 3'b111) && !(w && s1);
    if (w && s1) len = 1;
    else case (bc)
      3'b001: len = 2;
      3'b010: len = 4;
      3'b011: len = 8;
      3'b111: len = 256;
      default: len = 1;
    endcase
    m = 8'(len - 1);
    n = page ? run : ((run < len) ? run : len);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.c = model(c, m, xo && !page, k);
      e.l = !page && (k == len - 1);
      e.tag = tag;
      q.push_back(e);
    end
    start = 1'b1; scol = c; code = bc; il = xo; wr = w; sw = s1;
    @(posedge clk); #2;
    start = 1'b0;
    repeat (run - 1) begin @(posedge clk); #2; end
    if (do_stop) begin
      stop = 1'b1;
      @(posedge clk); #2;
      stop = 1'b0;
    end else if (!chain) begin
      @(posedge clk); #2;
    end
    if (!chain) repeat (2) begin @(posedge clk); #2; end
  endtask

  always @(posedge clk) cke_q <= cke;

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && valid) begin
        if (cke_q) begin
          if (q.size() == 0) begin
            chk(1'b0, "R5", "unexpected beat col", int'(col), 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(col == e.c, e.tag, "col", int'(col), int'(e.c));
            chk(last == e.l, e.tag, "last", int'(last), int'(e.l));
            prev_col = col;
          end
        end else begin
          chk(col == prev_col, "R11", "frozen col", int'(col), int'(prev_col));
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(valid == 1'b0 && last == 1'b0, "R1", "valid/last in reset",
        int'({valid, last}), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(valid == 1'b0 && last == 1'b0 && col == 8'h00, "R1", "idle after reset",
        int'({valid, last, col}), 0);
    mon_on = 1'b1;
    @(posedge clk); #2;

    // R2 R3: linear BL4 from unaligned start
    burst(8'h12, 3'b010, 1'b0, 1'b0, 1'b0, 4, 1'b0, 1'b0, "R3");
    // R4: interleaved BL8 vs linear BL8 from the same start
    burst(8'h35, 3'b011, 1'b1, 1'b0, 1'b0, 8, 1'b0, 1'b0, "R4");
    burst(8'h35, 3'b011, 1'b0, 1'b0, 1'b0, 8, 1'b0, 1'b0, "R3");
    burst(8'h07, 3'b001, 1'b1, 1'b0, 1'b0, 2, 1'b0, 1'b0, "R4");
    burst(8'hAE, 3'b010, 1'b1, 1'b0, 1'b0, 4, 1'b0, 1'b0, "R4");
    // R6: length codes, reserved codes behave as one beat
    burst(8'h20, 3'b000, 1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R6");
    burst(8'h21, 3'b100, 1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R6");
    burst(8'h22, 3'b101, 1'b1, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R6");
    burst(8'h23, 3'b110, 1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R6");
    // R7 R9: full row wraps past 255, interleave ignored, ended by stop
    burst(8'hFC, 3'b111, 1'b1, 1'b0, 1'b0, 10, 1'b1, 1'b0, "R7");
    // R8: single-write override for writes only
    burst(8'h51, 3'b011, 1'b0, 1'b1, 1'b1, 1, 1'b0, 1'b0, "R8");
    burst(8'h51, 3'b011, 1'b0, 1'b0, 1'b1, 8, 1'b0, 1'b0, "R8");
    burst(8'h62, 3'b010, 1'b0, 1'b1, 1'b0, 4, 1'b0, 1'b0, "R8");
    burst(8'h70, 3'b111, 1'b0, 1'b1, 1'b1, 1, 1'b0, 1'b0, "R8");
    // R9: stop in the middle of a BL8
    burst(8'h84, 3'b011, 1'b0, 1'b0, 1'b0, 3, 1'b1, 1'b0, "R9");
    // R10: restart in the middle of a burst
    burst(8'h90, 3'b011, 1'b1, 1'b0, 1'b0, 3, 1'b0, 1'b1, "R10");
    burst(8'hC6, 3'b010, 1'b0, 1'b0, 1'b0, 4, 1'b0, 1'b0, "R10");

    // R11: clock suspend during a BL8, requests made while frozen are dropped
    for (int k = 0; k < 8; k++) begin
      exp_t e;
      e.c = 8'h40 + 8'(k);
      e.l = (k == 7);
      e.tag = "R11";
      q.push_back(e);
    end
    start = 1'b1; scol = 8'h40; code = 3'b011; il = 1'b0; wr = 1'b0; sw = 1'b0;
    @(posedge clk); #2;
    start = 1'b0;
    @(posedge clk); #2;
    cke = 1'b0; start = 1'b1; scol = 8'h99; stop = 1'b1;
    repeat (3) begin @(posedge clk); #2; end
    cke = 1'b1; start = 1'b0; stop = 1'b0;
    repeat (9) begin @(posedge clk); #2; end

    @(negedge clk);
    chk(valid == 1'b0, "R5", "idle at end", int'(valid), 0);
    chk(q.size() == 0, "R5", "beats outstanding", q.size(), 0);
    summary();
  end
endmodule